// File: doc/BRIEF.md
# Self-Steering Open-Drain Data Line Repeater

This block joins two open-drain data lines, one on the host side and one on the card side, and carries traffic between them in both directions without a direction input. While idle it drives neither line and watches both. The first side seen pulling low becomes the driver for the transfer. After a fixed propagation delay for that direction, the block pulls the opposite line low. It holds that line low until the driving side lets go. Delays are counted in clock cycles: a longer one for card-to-host and a shorter one for host-to-card.

Once the driving side releases, the block drops its pull-down at once. It then waits out a guard interval before it looks at the lines again, so that the line it was holding is not taken for a new start as it rises. A session enable from the sequencer forces the block back to idle with both pull-downs off. Both line levels pass through a two-stage synchronizer before any decision is made. The same block serves any auxiliary line pair.

Top module: `iodir_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `host_pd` and `card_pd` are both 0.
- R2: With `sess_en` high and both lines high, neither pull-down is asserted.
- R3: If the host line is low (value 0 on `host_in`) while idle, `card_pd` goes to 1 on the (H2C_DLY+3)th rising edge after the first edge that samples the low level, provided the host line stays low.
- R4: If the card line is low while idle and the host line is high, `host_pd` goes to 1 on the (C2H_DLY+3)th rising edge after the first edge that samples the low level, provided the card line stays low.
- R5: A pull-down is asserted only if the driving line was low three edges earlier. When the driving line returns high, the pull-down drops on the third rising edge after the first edge that samples the high level.
- R6: After a pull-down is released, or a start is abandoned, the block ignores both lines for GUARD_CYC cycles. On the cycle after any release, neither pull-down is asserted.
- R7: If both lines are seen low in the same cycle while idle, the host side wins: only `card_pd` may be asserted.
- R8: When `sess_en` is 0, both pull-downs are 0 from the next edge on, and the block returns to idle. A line still held low when the enable returns starts a fresh transfer with the full delay.
- R9: `host_pd` and `card_pd` are never 1 at the same time.
- R10: A low pulse on the driving line that ends before its direction's delay has run out produces no pull-down on the other side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sess_en | input | 1 | Session enable from the activation sequencer |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_pd | output | 1 | Pull-down enable for the host-side line |
| card_pd | output | 1 | Pull-down enable for the card-side line |

## Verification
The properties assume that each line level reflects the wired-AND of the external driver and the block's own pull-down. They also assume `sess_en` is synchronous to `clk`, and that GUARD_CYC covers the synchronizer latency, so the echo of a released line is never seen as a start. The bench models both lines as open-drain nets that combine a driver on each side with the block's pull-downs. It changes drivers and the enable only on falling clock edges. Every mismatch therefore comes from the block's decisions and never from an impossible line level.

// File: rtl/iodir_pkg.sv
package iodir_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_H2C_WAIT = 3'd1,
    ST_H2C_DRV  = 3'd2,
    ST_C2H_WAIT = 3'd3,
    ST_C2H_DRV  = 3'd4,
    ST_GUARD    = 3'd5
  } dir_state_e;
endpackage

// File: rtl/iodir_sync.sv
module iodir_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // lines idle high, so every stage resets to 1
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/iodir_fsm.sv
module iodir_fsm
  import iodir_pkg::*;
#(
  parameter int H2C_DLY   = 5,
  parameter int C2H_DLY   = 20,
  parameter int GUARD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic host_hi,
  input  logic card_hi,
  output logic host_pd,
  output logic card_pd
);
  localparam int MAXD  = (C2H_DLY > H2C_DLY) ?
                         ((C2H_DLY > GUARD_CYC) ? C2H_DLY : GUARD_CYC) :
                         ((H2C_DLY > GUARD_CYC) ? H2C_DLY : GUARD_CYC);
  localparam int CW    = $clog2(MAXD + 1);
  localparam logic [CW-1:0] H2C_LD = CW'(H2C_DLY - 1);
  localparam logic [CW-1:0] C2H_LD = CW'(C2H_DLY - 1);
  localparam logic [CW-1:0] GRD_LD = CW'(GUARD_CYC - 1);

  dir_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          host_pd_q, card_pd_q;
  logic          host_pd_d, card_pd_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!host_hi) begin            // host wins on a tie
            state_d = ST_H2C_WAIT;
            cnt_d   = H2C_LD;
          end else if (!card_hi) begin
            state_d = ST_C2H_WAIT;
            cnt_d   = C2H_LD;
          end
        end
        ST_H2C_WAIT: begin
          if (host_hi) begin
            state_d = ST_GUARD;
            cnt_d   = GRD_LD;
          end else if (cnt_zero) begin
            state_d = ST_H2C_DRV;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_C2H_WAIT: begin
          if (card_hi) begin
            state_d = ST_GUARD;
            cnt_d   = GRD_LD;
          end else if (cnt_zero) begin
            state_d = ST_C2H_DRV;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_H2C_DRV: begin
          if (host_hi) begin
            state_d = ST_GUARD;
            cnt_d   = GRD_LD;
          end
        end
        ST_C2H_DRV: begin
          if (card_hi) begin
            state_d = ST_GUARD;
            cnt_d   = GRD_LD;
          end
        end
        ST_GUARD: begin
          if (cnt_zero) state_d = ST_IDLE;
          else          cnt_d   = cnt_q - 1'b1;
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  // pull-downs come straight from flops so a release never glitches
  assign host_pd_d = (state_d == ST_C2H_DRV);
  assign card_pd_d = (state_d == ST_H2C_DRV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      host_pd_q <= 1'b0;
      card_pd_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      host_pd_q <= host_pd_d;
      card_pd_q <= card_pd_d;
    end
  end

  assign host_pd = host_pd_q;
  assign card_pd = card_pd_q;
endmodule

// File: rtl/iodir_arbiter.sv
module iodir_arbiter #(
  parameter int H2C_DLY   = 5,
  parameter int C2H_DLY   = 20,
  parameter int GUARD_CYC = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sess_en,
  input  logic host_in,
  input  logic card_in,
  output logic host_pd,
  output logic card_pd
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lv, syn_lv;

  assign raw_lv = {card_in, host_in};

  iodir_sync #(.W(NLINES), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_lv),
    .q     (syn_lv)
  );

  iodir_fsm #(
    .H2C_DLY   (H2C_DLY),
    .C2H_DLY   (C2H_DLY),
    .GUARD_CYC (GUARD_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (sess_en),
    .host_hi (syn_lv[0]),
    .card_hi (syn_lv[1]),
    .host_pd (host_pd),
    .card_pd (card_pd)
  );
endmodule

// File: rtl/iodir_arbiter_chk.sv
module iodir_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic sess_en,
  input logic host_in,
  input logic card_in,
  input logic host_pd,
  input logic card_pd
);
  // R9
  pd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pd && card_pd));

  // R8
  session_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_en |=> (!host_pd && !card_pd));

  // R6
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(card_pd) || $fell(host_pd)) |-> (!host_pd && !card_pd));

  // R5
  card_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_pd |-> (!$past(host_in, 3) && $past(sess_en)));

  // R5
  host_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_pd |-> (!$past(card_in, 3) && $past(sess_en)));
endmodule

bind iodir_arbiter iodir_arbiter_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sess_en (sess_en),
  .host_in (host_in),
  .card_in (card_in),
  .host_pd (host_pd),
  .card_pd (card_pd)
);

// File: tb/iodir_arbiter_bench.sv
module iodir_arbiter_bench;
  localparam int H2C = 5;
  localparam int C2H = 20;
  localparam int GRD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sess_en = 1'b0;
  logic host_drv = 1'b0;
  logic card_drv = 1'b0;
  logic host_in, card_in, host_pd, card_pd;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain nets: low if either party pulls
  assign host_in = !(host_drv || host_pd);
  assign card_in = !(card_drv || card_pd);

  iodir_arbiter #(.H2C_DLY(H2C), .C2H_DLY(C2H), .GUARD_CYC(GRD)) u_iodir_arbiter (
    .clk(clk), .rst_n(rst_n), .sess_en(sess_en),
    .host_in(host_in), .card_in(card_in),
    .host_pd(host_pd), .card_pd(card_pd)
  );

  // behavioural reference
  bit    hq[$];
  bit    cq[$];
  string m_mode;
  int    m_left;
  bit    exp_h, exp_c;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = '{1'b1, 1'b1};
      cq = '{1'b1, 1'b1};
      m_mode = "idle";
      m_left = 0;
      exp_h = 0;
      exp_c = 0;
    end else begin
      bit h, c;
      h = hq.pop_front();
      c = cq.pop_front();
      hq.push_back(host_in);
      cq.push_back(card_in);
      if (!sess_en) begin
        m_mode = "idle";
        m_left = 0;
      end else if (m_mode == "idle") begin
        if (!h)      begin m_mode = "h_wait"; m_left = H2C; end
        else if (!c) begin m_mode = "c_wait"; m_left = C2H; end
      end else if (m_mode == "h_wait" || m_mode == "c_wait") begin
        bit src;
        src = (m_mode == "h_wait") ? h : c;
        if (src) begin
          m_mode = "guard"; m_left = GRD;
        end else begin
          m_left--;
          if (m_left == 0) m_mode = (m_mode == "h_wait") ? "h_drv" : "c_drv";
        end
      end else if (m_mode == "h_drv") begin
        if (h) begin m_mode = "guard"; m_left = GRD; end
      end else if (m_mode == "c_drv") begin
        if (c) begin m_mode = "guard"; m_left = GRD; end
      end else begin
        m_left--;
        if (m_left == 0) m_mode = "idle";
      end
      exp_c = (m_mode == "h_drv");
      exp_h = (m_mode == "c_drv");
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 R3 R4 R5 R6 R7 R8 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(host_pd == exp_h, "model host_pd (R4 R5 R6 R8)", host_pd, exp_h);
      chk(card_pd == exp_c, "model card_pd (R3 R5 R6 R7 R10)", card_pd, exp_c);
      chk(!(host_pd && card_pd), "R9 both pull-downs", 1, 0);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        miscompares++;
        $display("FAIL watchdog (all requirements): actual %0d expected <= 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin : stim
    wait_n(3);
    // R1
    chk(!host_pd && !card_pd, "R1 pull-downs in reset", {host_pd, card_pd}, 0);
    rst_n = 1'b1;
    wait_n(1);
    chk(!host_pd && !card_pd, "R1 pull-downs after reset", {host_pd, card_pd}, 0);
    sess_en = 1'b1;
    wait_n(10);
    // R2
    chk(!host_pd && !card_pd, "R2 idle lines", {host_pd, card_pd}, 0);

    // R3 host drives the card line
    host_drv = 1'b1;
    wait_n(H2C + 2);
    chk(card_pd == 1'b0, "R3 card_pd before delay", card_pd, 0);
    wait_n(1);
    chk(card_pd == 1'b1, "R3 card_pd after delay", card_pd, 1);
    wait_n(10);
    // R5 release
    host_drv = 1'b0;
    wait_n(2);
    chk(card_pd == 1'b1, "R5 card_pd held through sync", card_pd, 1);
    wait_n(1);
    chk(card_pd == 1'b0, "R5 card_pd released", card_pd, 0);
    // R6 echo of the rising card line must not start host_pd
    for (int i = 0; i < GRD + 4; i++) begin
      wait_n(1);
      chk(host_pd == 1'b0, "R6 no echo drive", host_pd, 0);
    end
    wait_n(5);

    // R4 card drives the host line
    card_drv = 1'b1;
    wait_n(C2H + 2);
    chk(host_pd == 1'b0, "R4 host_pd before delay", host_pd, 0);
    wait_n(1);
    chk(host_pd == 1'b1, "R4 host_pd after delay", host_pd, 1);
    wait_n(5);
    card_drv = 1'b0;
    wait_n(3);
    chk(host_pd == 1'b0, "R5 host_pd released", host_pd, 0);
    wait_n(GRD + 6);

    // R7 simultaneous fall
    host_drv = 1'b1;
    card_drv = 1'b1;
    wait_n(H2C + 6);
    chk(card_pd == 1'b1, "R7 host wins, card_pd", card_pd, 1);
    chk(host_pd == 1'b0, "R7 host wins, host_pd", host_pd, 0);
    host_drv = 1'b0;
    card_drv = 1'b0;
    wait_n(GRD + 8);

    // R10 short host pulse
    host_drv = 1'b1;
    wait_n(2);
    host_drv = 1'b0;
    for (int i = 0; i < 12; i++) begin
      wait_n(1);
      chk(card_pd == 1'b0, "R10 short pulse ignored", card_pd, 0);
    end
    wait_n(GRD + 4);

    // R8 enable removed mid-transfer
    card_drv = 1'b1;
    wait_n(C2H + 5);
    chk(host_pd == 1'b1, "R8 transfer active before disable", host_pd, 1);
    sess_en = 1'b0;
    wait_n(1);
    chk(!host_pd && !card_pd, "R8 disable drops pull-downs", {host_pd, card_pd}, 0);
    wait_n(5);
    chk(host_pd == 1'b0, "R8 stays off while disabled", host_pd, 0);
    sess_en = 1'b1;
    wait_n(C2H);
    chk(host_pd == 1'b0, "R8 restart waits full delay", host_pd, 0);
    wait_n(3);
    chk(host_pd == 1'b1, "R8 restart drives", host_pd, 1);
    card_drv = 1'b0;
    wait_n(GRD + 8);
    chk(!host_pd && !card_pd, "R2 idle at end", {host_pd, card_pd}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule